// File: doc/BRIEF.md
# Page Translation Cache with Permission Flags

This block is a small, fully associative cache of address translations. It sits between a processor core and the page-table walker. It turns a virtual address into a physical address in one cycle when the translation is cached. It also enforces the per-page rights: write permission, execute permission and user-mode access. On a miss it asks the walker for the entry. Each lookup answers in the cycle after the request with one of three results: a hit carrying the physical address, a permission fault carrying a cause code and the offending virtual address, or a walk request carrying the virtual page number.

Every entry can map a 4 KiB page, a 2 MiB page or a 1 GiB page. Each size is 512 times the one below it, so an entry compares 9 or 18 fewer low bits of the page number. The cache keeps its own copy of each page's accessed and dirty bits. When an access is the first to set one of those bits, the cache asks the walker to write the bit back to memory.

Software loads a new root pointer for the page tables on each switch of address space. That load drops every cached entry that is not marked global. Global entries stay.

Top module: `xlat_cache`

## Requirements
- R1: A lookup request in cycle N produces exactly one response in cycle N+1, judged against the contents the cache held before the edge that ends cycle N. The response is a hit without fault, a fault, or a miss, and never more than one of these.
- R2: Entry size is set by the fill level: 0 means 4 KiB, 1 means 2 MiB and 2 or 3 means 1 GiB. The compare ignores the low 0, 9 or 18 bits of the virtual page number for these sizes. The physical address is the entry's frame number with those same low bits taken from the virtual page number, followed by the 12-bit page offset.
- R3: A lookup that matches no valid entry raises walk_req and walk_vpn. It raises neither rsp_hit nor rsp_fault, and rsp_paddr reads zero.
- R4: A hit is refused in three cases: a user-mode access to a page without the user flag (cause 3), a write to a page without the writable flag (cause 1), and a fetch from a page with the no-execute flag (cause 2). When more than one case applies, they rank in that order. A refused hit raises rsp_fault with the cause code, puts the virtual address on rsp_fault_va, and drives rsp_paddr to zero.
- R5: A permitted hit on an entry whose accessed bit is clear raises upd_req. A permitted write on an entry whose dirty bit is clear also raises upd_req. upd_dirty is 1 for a write and upd_vpn carries the page number. The cached bits are then set, so repeating the same access raises no request. A faulting access changes no bit and requests nothing.
- R6: A pulse on root_wr loads root_val into root_ptr on that edge. On the same edge it invalidates every entry whose global flag is clear. Global entries keep hitting afterwards. A fill presented in the same cycle is written after the invalidation and is kept.
- R7: A fill goes into the lowest-numbered invalid entry, counting any invalidation on the same edge. When every entry is valid, the fill replaces the entry named by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping at NUM_ENT, on each such replacement only.
- R8: After reset no entry is valid, root_ptr is zero, and rsp_valid, walk_req and upd_req are low.
- R9: The access type on lk_acc is encoded as 0 for read, 1 for write and 2 for instruction fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+12 | Virtual address of the lookup |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| lk_user | input | 1 | 1 when the core runs in user mode |
| fill_valid | input | 1 | Walker delivers an entry |
| fill_vpn | input | VPN_W | Virtual page number of the entry |
| fill_pfn | input | PFN_W | Frame number of the entry |
| fill_level | input | 2 | 0 = 4 KiB, 1 = 2 MiB, 2/3 = 1 GiB |
| fill_writable | input | 1 | Writes allowed |
| fill_no_exec | input | 1 | Fetches refused |
| fill_user | input | 1 | User-mode access allowed |
| fill_global | input | 1 | Entry survives root loads |
| fill_accessed | input | 1 | Accessed bit as stored in memory |
| fill_dirty | input | 1 | Dirty bit as stored in memory |
| root_wr | input | 1 | Load a new page-table root |
| root_val | input | ROOT_W | New root pointer |
| root_ptr | output | ROOT_W | Active root pointer |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An entry matched |
| rsp_paddr | output | PFN_W+12 | Physical address on a permitted hit, else zero |
| rsp_fault | output | 1 | Permission fault |
| rsp_cause | output | 2 | Fault cause: 1 write, 2 execute, 3 privilege |
| rsp_fault_va | output | VPN_W+12 | Faulting virtual address, else zero |
| walk_req | output | 1 | Miss; the walker should fetch the entry |
| walk_vpn | output | VPN_W | Page number to walk |
| upd_req | output | 1 | Set flag bits in the in-memory entry |
| upd_vpn | output | VPN_W | Page number whose entry is updated |
| upd_dirty | output | 1 | Set the dirty bit as well as the accessed bit |

## Verification
The bench builds the cache with a 27-bit page number, a 32-bit frame number, a 44-bit root and 8 entries. With 8 entries, filling the cache, overflowing it twice and then loading a new root is only about a dozen fills, so a short run covers the round-robin wrap and the first-invalid rule. The 27-bit page number lets the 2 MiB and 1 GiB entries sit next to 4 KiB ones without overlapping, so the bench can probe both sides of each masked range boundary. The combined root load and fill shows that a global entry survives and that the victim is chosen after the invalidation.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_WRITE = 2'd1,
        CAUSE_EXEC  = 2'd2,
        CAUSE_PRIV  = 2'd3
    } cause_e;

    localparam int unsigned PAGE_OFF_W = 12;
    localparam int unsigned LEVEL_STEP = 9;

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int unsigned NUM_ENT = 8,
    parameter int unsigned VPN_W   = 27,
    parameter int unsigned STEP    = 9,
    parameter int unsigned IDX_W   = $clog2(NUM_ENT)
) (
    input  logic [VPN_W-1:0]   key,
    input  logic [NUM_ENT-1:0] ent_valid,
    input  logic [VPN_W-1:0]   ent_vpn   [NUM_ENT],
    input  logic [1:0]         ent_level [NUM_ENT],
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx
);
    localparam logic [VPN_W-1:0] MASK_SMALL = '1;
    localparam logic [VPN_W-1:0] MASK_MID   = MASK_SMALL << STEP;
    localparam logic [VPN_W-1:0] MASK_BIG   = MASK_SMALL << (2 * STEP);

    logic [NUM_ENT-1:0] match;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        logic [VPN_W-1:0] cmp_mask;
        always_comb begin
            unique case (ent_level[g])
                2'd0:    cmp_mask = MASK_SMALL;
                2'd1:    cmp_mask = MASK_MID;
                default: cmp_mask = MASK_BIG;
            endcase
        end
        assign match[g] = ent_valid[g] && (((key ^ ent_vpn[g]) & cmp_mask) == '0);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
(
    input  logic [1:0] acc,
    input  logic       user_mode,
    input  logic       pg_writable,
    input  logic       pg_no_exec,
    input  logic       pg_user,
    output logic       fault,
    output logic [1:0] cause
);
    always_comb begin
        cause = CAUSE_NONE;
        if (user_mode && !pg_user) begin
            cause = CAUSE_PRIV;
        end else if (acc == ACC_WRITE && !pg_writable) begin
            cause = CAUSE_WRITE;
        end else if (acc == ACC_FETCH && pg_no_exec) begin
            cause = CAUSE_EXEC;
        end
        fault = (cause != CAUSE_NONE);
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int unsigned NUM_ENT = 8,
    parameter int unsigned IDX_W   = $clog2(NUM_ENT)
) (
    input  logic [NUM_ENT-1:0] ent_valid,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               all_full
);
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign all_full = &ent_valid;
    assign victim   = all_full ? rr_ptr : free_idx;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int unsigned VPN_W   = 27,
    parameter int unsigned PFN_W   = 32,
    parameter int unsigned ROOT_W  = 44,
    parameter int unsigned NUM_ENT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [VPN_W+11:0]     lk_vaddr,
    input  logic [1:0]            lk_acc,
    input  logic                  lk_user,
    input  logic                  fill_valid,
    input  logic [VPN_W-1:0]      fill_vpn,
    input  logic [PFN_W-1:0]      fill_pfn,
    input  logic [1:0]            fill_level,
    input  logic                  fill_writable,
    input  logic                  fill_no_exec,
    input  logic                  fill_user,
    input  logic                  fill_global,
    input  logic                  fill_accessed,
    input  logic                  fill_dirty,
    input  logic                  root_wr,
    input  logic [ROOT_W-1:0]     root_val,
    output logic [ROOT_W-1:0]     root_ptr,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [PFN_W+11:0]     rsp_paddr,
    output logic                  rsp_fault,
    output logic [1:0]            rsp_cause,
    output logic [VPN_W+11:0]     rsp_fault_va,
    output logic                  walk_req,
    output logic [VPN_W-1:0]      walk_vpn,
    output logic                  upd_req,
    output logic [VPN_W-1:0]      upd_vpn,
    output logic                  upd_dirty
);
    localparam int unsigned OFF_W = PAGE_OFF_W;
    localparam int unsigned VA_W  = VPN_W + OFF_W;
    localparam int unsigned PA_W  = PFN_W + OFF_W;
    localparam int unsigned IDX_W = $clog2(NUM_ENT);
    localparam logic [PFN_W-1:0] PFN_ONES = '1;
    localparam logic [PFN_W-1:0] LOW_MID  = ~(PFN_ONES << LEVEL_STEP);
    localparam logic [PFN_W-1:0] LOW_BIG  = ~(PFN_ONES << (2 * LEVEL_STEP));

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic [1:0]       level;
        logic             writable;
        logic             no_exec;
        logic             user_ok;
        logic             global_pg;
        logic             accessed;
        logic             dirty;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_ENT-1:0] ents;
        logic [IDX_W-1:0]     rr;
        logic [ROOT_W-1:0]    root;
        logic                 rsp_valid;
        logic                 rsp_hit;
        logic                 rsp_fault;
        logic [1:0]           cause;
        logic [PA_W-1:0]      paddr;
        logic [VA_W-1:0]      fault_va;
        logic                 walk;
        logic [VPN_W-1:0]     walk_vpn;
        logic                 upd;
        logic [VPN_W-1:0]     upd_vpn;
        logic                 upd_dirty;
    } state_t;

    state_t st_d, st_q;

    // Entry fields flattened for the submodules.
    logic [NUM_ENT-1:0] valid_q;
    logic [NUM_ENT-1:0] global_q;
    logic [VPN_W-1:0]   vpn_arr   [NUM_ENT];
    logic [1:0]         level_arr [NUM_ENT];

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            valid_q[i]   = st_q.ents[i].valid;
            global_q[i]  = st_q.ents[i].global_pg;
            vpn_arr[i]   = st_q.ents[i].vpn;
            level_arr[i] = st_q.ents[i].level;
        end
    end

    logic [VPN_W-1:0] lk_vpn;
    logic [OFF_W-1:0] lk_off;
    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    xlat_match #(
        .NUM_ENT (NUM_ENT),
        .VPN_W   (VPN_W),
        .STEP    (LEVEL_STEP),
        .IDX_W   (IDX_W)
    ) u_match (
        .key       (lk_vpn),
        .ent_valid (valid_q),
        .ent_vpn   (vpn_arr),
        .ent_level (level_arr),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    entry_t hit_ent;
    assign hit_ent = st_q.ents[hit_idx];

    logic       perm_fault;
    logic [1:0] perm_cause;

    xlat_perm u_perm (
        .acc         (lk_acc),
        .user_mode   (lk_user),
        .pg_writable (hit_ent.writable),
        .pg_no_exec  (hit_ent.no_exec),
        .pg_user     (hit_ent.user_ok),
        .fault       (perm_fault),
        .cause       (perm_cause)
    );

    // Victim choice sees the valid set after any same-edge invalidation.
    logic [NUM_ENT-1:0] valid_post;
    logic [IDX_W-1:0]   victim;
    logic               all_full;

    assign valid_post = root_wr ? (valid_q & global_q) : valid_q;

    xlat_victim #(
        .NUM_ENT (NUM_ENT),
        .IDX_W   (IDX_W)
    ) u_victim (
        .ent_valid (valid_post),
        .rr_ptr    (st_q.rr),
        .victim    (victim),
        .all_full  (all_full)
    );

    // Frame number with the low bits of huge pages taken from the virtual side.
    logic [PFN_W-1:0] low_sel;
    logic [PFN_W-1:0] pfn_eff;
    always_comb begin
        unique case (hit_ent.level)
            2'd0:    low_sel = '0;
            2'd1:    low_sel = LOW_MID;
            default: low_sel = LOW_BIG;
        endcase
        pfn_eff = (hit_ent.pfn & ~low_sel) | (PFN_W'(lk_vpn) & low_sel);
    end

    logic is_write;
    logic need_upd;
    assign is_write = (lk_acc == ACC_WRITE);
    assign need_upd = !hit_ent.accessed || (is_write && !hit_ent.dirty);

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_fault = 1'b0;
        st_d.cause     = CAUSE_NONE;
        st_d.paddr     = '0;
        st_d.fault_va  = '0;
        st_d.walk      = 1'b0;
        st_d.walk_vpn  = '0;
        st_d.upd       = 1'b0;
        st_d.upd_vpn   = '0;
        st_d.upd_dirty = 1'b0;

        if (lk_valid) begin
            st_d.rsp_valid = 1'b1;
            if (!hit) begin
                st_d.walk     = 1'b1;
                st_d.walk_vpn = lk_vpn;
            end else begin
                st_d.rsp_hit = 1'b1;
                if (perm_fault) begin
                    st_d.rsp_fault = 1'b1;
                    st_d.cause     = perm_cause;
                    st_d.fault_va  = lk_vaddr;
                end else begin
                    st_d.paddr = {pfn_eff, lk_off};
                    if (need_upd) begin
                        st_d.upd       = 1'b1;
                        st_d.upd_vpn   = lk_vpn;
                        st_d.upd_dirty = is_write;
                        st_d.ents[hit_idx].accessed = 1'b1;
                        if (is_write) st_d.ents[hit_idx].dirty = 1'b1;
                    end
                end
            end
        end

        if (root_wr) begin
            st_d.root = root_val;
            for (int i = 0; i < NUM_ENT; i++) begin
                if (!st_q.ents[i].global_pg) st_d.ents[i].valid = 1'b0;
            end
        end

        if (fill_valid) begin
            st_d.ents[victim].valid     = 1'b1;
            st_d.ents[victim].vpn       = fill_vpn;
            st_d.ents[victim].pfn       = fill_pfn;
            st_d.ents[victim].level     = fill_level;
            st_d.ents[victim].writable  = fill_writable;
            st_d.ents[victim].no_exec   = fill_no_exec;
            st_d.ents[victim].user_ok   = fill_user;
            st_d.ents[victim].global_pg = fill_global;
            st_d.ents[victim].accessed  = fill_accessed;
            st_d.ents[victim].dirty     = fill_dirty;
            if (all_full) begin
                st_d.rr = (st_q.rr == IDX_W'(NUM_ENT - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign root_ptr     = st_q.root;
    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_hit      = st_q.rsp_hit;
    assign rsp_paddr    = st_q.paddr;
    assign rsp_fault    = st_q.rsp_fault;
    assign rsp_cause    = st_q.cause;
    assign rsp_fault_va = st_q.fault_va;
    assign walk_req     = st_q.walk;
    assign walk_vpn     = st_q.walk_vpn;
    assign upd_req      = st_q.upd;
    assign upd_vpn      = st_q.upd_vpn;
    assign upd_dirty    = st_q.upd_dirty;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int unsigned VPN_W  = 27,
    parameter int unsigned ROOT_W = 44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W+11:0] lk_vaddr,
    input logic [1:0]        lk_acc,
    input logic              root_wr,
    input logic [ROOT_W-1:0] root_val,
    input logic [ROOT_W-1:0] root_ptr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic [1:0]        rsp_cause,
    input logic [VPN_W+11:0] rsp_fault_va,
    input logic              walk_req,
    input logic              upd_req,
    input logic              upd_dirty
);
    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(lk_valid));

    assert_single_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit && !rsp_fault, rsp_fault, walk_req}) &&
        ((rsp_hit || walk_req) == rsp_valid));

    assert_miss_no_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (!rsp_hit && !rsp_fault));

    assert_fault_reports_va_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_cause != CAUSE_NONE && rsp_fault_va == $past(lk_vaddr)));

    assert_write_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && rsp_cause == CAUSE_WRITE) |-> $past(lk_acc) == ACC_WRITE);

    assert_exec_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && rsp_cause == CAUSE_EXEC) |-> $past(lk_acc) == ACC_FETCH);

    assert_update_only_on_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |-> (rsp_hit && !rsp_fault));

    assert_dirty_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_dirty |-> (upd_req && $past(lk_acc) == ACC_WRITE));

    assert_root_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        root_wr |=> root_ptr == $past(root_val));

    assert_root_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !root_wr |=> $stable(root_ptr));

endmodule

bind xlat_cache xlat_cache_chk #(
    .VPN_W  (VPN_W),
    .ROOT_W (ROOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_vaddr     (lk_vaddr),
    .lk_acc       (lk_acc),
    .root_wr      (root_wr),
    .root_val     (root_val),
    .root_ptr     (root_ptr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_fault    (rsp_fault),
    .rsp_cause    (rsp_cause),
    .rsp_fault_va (rsp_fault_va),
    .walk_req     (walk_req),
    .upd_req      (upd_req),
    .upd_dirty    (upd_dirty)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
    localparam int unsigned VPN_W   = 27;
    localparam int unsigned PFN_W   = 32;
    localparam int unsigned ROOT_W  = 44;
    localparam int unsigned NUM_ENT = 8;
    localparam int unsigned VA_W    = VPN_W + 12;
    localparam int unsigned PA_W    = PFN_W + 12;
    localparam time         CLK_PERIOD = 10ns;
    localparam int          WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VA_W-1:0]   lk_vaddr = '0;
    logic [1:0]        lk_acc = '0;
    logic              lk_user = 1'b0;
    logic              fill_valid = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic [1:0]        fill_level = '0;
    logic              fill_writable = 1'b0;
    logic              fill_no_exec = 1'b0;
    logic              fill_user = 1'b0;
    logic              fill_global = 1'b0;
    logic              fill_accessed = 1'b0;
    logic              fill_dirty = 1'b0;
    logic              root_wr = 1'b0;
    logic [ROOT_W-1:0] root_val = '0;
    logic [ROOT_W-1:0] root_ptr;
    logic              rsp_valid, rsp_hit, rsp_fault, walk_req, upd_req, upd_dirty;
    logic [PA_W-1:0]   rsp_paddr;
    logic [1:0]        rsp_cause;
    logic [VA_W-1:0]   rsp_fault_va;
    logic [VPN_W-1:0]  walk_vpn, upd_vpn;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_cache #(
        .VPN_W (VPN_W), .PFN_W (PFN_W), .ROOT_W (ROOT_W), .NUM_ENT (NUM_ENT)
    ) i_xlat_cache (
        .clk (clk), .rst_n (rst_n),
        .lk_valid (lk_valid), .lk_vaddr (lk_vaddr), .lk_acc (lk_acc), .lk_user (lk_user),
        .fill_valid (fill_valid), .fill_vpn (fill_vpn), .fill_pfn (fill_pfn),
        .fill_level (fill_level), .fill_writable (fill_writable), .fill_no_exec (fill_no_exec),
        .fill_user (fill_user), .fill_global (fill_global), .fill_accessed (fill_accessed),
        .fill_dirty (fill_dirty), .root_wr (root_wr), .root_val (root_val), .root_ptr (root_ptr),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault), .rsp_cause (rsp_cause), .rsp_fault_va (rsp_fault_va),
        .walk_req (walk_req), .walk_vpn (walk_vpn), .upd_req (upd_req),
        .upd_vpn (upd_vpn), .upd_dirty (upd_dirty)
    );

    typedef struct {
        logic             hit;
        logic             fault;
        logic [1:0]       cause;
        logic [PA_W-1:0]  pa;
        logic [VA_W-1:0]  fva;
        logic             walk;
        logic [VPN_W-1:0] wvpn;
        logic             upd;
        logic [VPN_W-1:0] uvpn;
        logic             udirty;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   cycles   = 0;

    task automatic check(input bit ok, input string tag, input string got, input string want);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %s expected %s", tag, got, want);
        end
    endtask

    // Monitor: compare each response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected response", "response", "none");
            end else begin
                exp_t e;
                bit   ok;
                e  = exp_q.pop_front();
                ok = (rsp_hit == e.hit) && (rsp_fault == e.fault) && (rsp_cause == e.cause) &&
                     (rsp_paddr == e.pa) && (rsp_fault_va == e.fva) && (walk_req == e.walk) &&
                     (walk_vpn == e.wvpn) && (upd_req == e.upd) && (upd_vpn == e.uvpn) &&
                     (upd_dirty == e.udirty);
                check(ok, e.tag,
                      $sformatf("hit=%0b flt=%0b c=%0d pa=%h fva=%h walk=%0b/%h upd=%0b/%h d=%0b",
                                rsp_hit, rsp_fault, rsp_cause, rsp_paddr, rsp_fault_va,
                                walk_req, walk_vpn, upd_req, upd_vpn, upd_dirty),
                      $sformatf("hit=%0b flt=%0b c=%0d pa=%h fva=%h walk=%0b/%h upd=%0b/%h d=%0b",
                                e.hit, e.fault, e.cause, e.pa, e.fva,
                                e.walk, e.wvpn, e.upd, e.uvpn, e.udirty));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // Driver: one lookup; epfn is the effective frame number on a permitted hit.
    task automatic look(input logic [VPN_W-1:0] vpn, input logic [11:0] off,
                        input logic [1:0] acc, input logic usr,
                        input logic eh, input logic ef, input logic [1:0] ec,
                        input logic [PFN_W-1:0] epfn, input logic eu, input logic eud,
                        input string tag);
        exp_t e;
        e.hit    = eh;
        e.fault  = ef;
        e.cause  = ec;
        e.pa     = (eh && !ef) ? {epfn, off} : '0;
        e.fva    = ef ? {vpn, off} : '0;
        e.walk   = !eh;
        e.wvpn   = !eh ? vpn : '0;
        e.upd    = eu;
        e.uvpn   = eu ? vpn : '0;
        e.udirty = eud;
        e.tag    = tag;
        exp_q.push_back(e);
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        lk_acc   = acc;
        lk_user  = usr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic set_fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                            input logic [1:0] lvl, input logic w, input logic nx,
                            input logic u, input logic g, input logic a, input logic d);
        fill_valid    = 1'b1;
        fill_vpn      = vpn;
        fill_pfn      = pfn;
        fill_level    = lvl;
        fill_writable = w;
        fill_no_exec  = nx;
        fill_user     = u;
        fill_global   = g;
        fill_accessed = a;
        fill_dirty    = d;
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                        input logic [1:0] lvl, input logic w, input logic nx,
                        input logic u, input logic g, input logic a, input logic d);
        set_fill(vpn, pfn, lvl, w, nx, u, g, a, d);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(root_ptr == '0, "R8 root_ptr after reset", $sformatf("%h", root_ptr), "0");
        check(!rsp_valid && !walk_req && !upd_req, "R8 outputs idle after reset",
              $sformatf("%0b%0b%0b", rsp_valid, walk_req, upd_req), "000");
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && !walk_req && !upd_req, "R8 idle after release",
              $sformatf("%0b%0b%0b", rsp_valid, walk_req, upd_req), "000");

        // R3: empty cache misses
        look(27'h12345, 12'h678, 2'd0, 1'b1, 0, 0, 0, '0, 0, 0, "R3 miss on empty cache");

        // 4 KiB user page, accessed and dirty clear
        fill(27'h12345, 32'h0000ABCD, 2'd0, 1, 0, 1, 0, 0, 0);
        look(27'h12345, 12'h678, 2'd0, 1'b1, 1, 0, 0, 32'h0000ABCD, 1, 0, "R5 first read sets accessed");
        look(27'h12345, 12'h678, 2'd0, 1'b1, 1, 0, 0, 32'h0000ABCD, 0, 0, "R5 second read no update");
        look(27'h12345, 12'h004, 2'd1, 1'b1, 1, 0, 0, 32'h0000ABCD, 1, 1, "R5 first write sets dirty");
        look(27'h12345, 12'h004, 2'd1, 1'b1, 1, 0, 0, 32'h0000ABCD, 0, 0, "R5 second write no update");
        look(27'h12345, 12'hFFF, 2'd2, 1'b1, 1, 0, 0, 32'h0000ABCD, 0, 0, "R9 fetch from executable page");
        look(27'h12346, 12'h000, 2'd0, 1'b0, 0, 0, 0, '0, 0, 0, "R3 neighbour page misses");

        // 2 MiB kernel page, no execute
        fill(27'h00200, 32'h00004000, 2'd1, 1, 1, 0, 0, 1, 1);
        look(27'h002AB, 12'h010, 2'd0, 1'b0, 1, 0, 0, 32'h000040AB, 0, 0, "R2 2 MiB hit composes address");
        look(27'h002AB, 12'h010, 2'd0, 1'b1, 1, 1, 3, '0, 0, 0, "R4 user access to kernel page");
        look(27'h003FF, 12'h020, 2'd2, 1'b0, 1, 1, 2, '0, 0, 0, "R4 fetch from no-exec page");
        look(27'h00400, 12'h000, 2'd0, 1'b0, 0, 0, 0, '0, 0, 0, "R2 just above 2 MiB range misses");

        // 1 GiB global read-only kernel page
        fill(27'h0040000, 32'h00800000, 2'd2, 0, 0, 0, 1, 1, 1);
        look(27'h0041234, 12'h100, 2'd1, 1'b0, 1, 1, 1, '0, 0, 0, "R4 write to read-only page");
        look(27'h0041234, 12'h100, 2'd1, 1'b1, 1, 1, 3, '0, 0, 0, "R4 privilege outranks write");
        look(27'h0041234, 12'h100, 2'd0, 1'b0, 1, 0, 0, 32'h00801234, 0, 0, "R2 1 GiB hit composes address");
        look(27'h007FFFF, 12'hABC, 2'd2, 1'b0, 1, 0, 0, 32'h0083FFFF, 0, 0, "R2 1 GiB top page");
        look(27'h0080000, 12'h000, 2'd0, 1'b0, 0, 0, 0, '0, 0, 0, "R2 just above 1 GiB range misses");

        // R6: root load flushes non-global entries
        root_wr  = 1'b1;
        root_val = 44'h0DEAD000;
        @(negedge clk);
        root_wr = 1'b0;
        check(root_ptr == 44'h0DEAD000, "R6 root pointer loaded",
              $sformatf("%h", root_ptr), "0dead000");
        look(27'h12345, 12'h678, 2'd0, 1'b1, 0, 0, 0, '0, 0, 0, "R6 4 KiB entry flushed");
        look(27'h002AB, 12'h010, 2'd0, 1'b0, 0, 0, 0, '0, 0, 0, "R6 2 MiB entry flushed");
        look(27'h0041234, 12'h100, 2'd0, 1'b0, 1, 0, 0, 32'h00801234, 0, 0, "R6 global entry survives");

        // R7: fill free slots (0,1,3..7), then overflow twice
        for (int k = 0; k < 7; k++) fill(27'h1000 + k, 32'h5000 + k, 2'd0, 1, 0, 1, 0, 1, 1);
        for (int k = 0; k < 7; k++)
            look(27'h1000 + k, 12'h0, 2'd0, 1'b1, 1, 0, 0, 32'h5000 + k, 0, 0, "R7 free slots filled first");
        look(27'h0041234, 12'h100, 2'd0, 1'b0, 1, 0, 0, 32'h00801234, 0, 0, "R7 global kept while free slots used");
        fill(27'h1007, 32'h5007, 2'd0, 1, 0, 1, 0, 1, 1);
        fill(27'h1008, 32'h5008, 2'd0, 1, 0, 1, 0, 1, 1);
        look(27'h1000, 12'h0, 2'd0, 1'b1, 0, 0, 0, '0, 0, 0, "R7 slot 0 replaced first");
        look(27'h1001, 12'h0, 2'd0, 1'b1, 0, 0, 0, '0, 0, 0, "R7 slot 1 replaced second");
        look(27'h1002, 12'h0, 2'd0, 1'b1, 1, 0, 0, 32'h5002, 0, 0, "R7 slot 3 untouched");
        look(27'h1007, 12'h0, 2'd0, 1'b1, 1, 0, 0, 32'h5007, 0, 0, "R7 new entry present");
        look(27'h1008, 12'h0, 2'd0, 1'b1, 1, 0, 0, 32'h5008, 0, 0, "R7 second new entry present");
        look(27'h0041234, 12'h100, 2'd0, 1'b0, 1, 0, 0, 32'h00801234, 0, 0, "R7 global entry not yet victim");

        // R6/R7: root load and fill together; fill goes to slot 0 after the flush
        set_fill(27'h2000, 32'h6000, 2'd0, 1, 0, 1, 0, 1, 1);
        root_wr  = 1'b1;
        root_val = 44'h0BEEF000;
        @(negedge clk);
        fill_valid = 1'b0;
        root_wr    = 1'b0;
        look(27'h2000, 12'h0, 2'd0, 1'b1, 1, 0, 0, 32'h6000, 0, 0, "R6 fill with root load kept");
        look(27'h0041234, 12'h100, 2'd0, 1'b0, 1, 0, 0, 32'h00801234, 0, 0, "R7 global kept, victim after flush");
        look(27'h1007, 12'h0, 2'd0, 1'b1, 0, 0, 0, '0, 0, 0, "R6 non-global flushed with fill");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R1 every lookup answered",
              $sformatf("%0d pending", exp_q.size()), "0 pending");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule